// File: doc/BRIEF.md
# Masked Block-Write Path with Color Register

This block sits between the pin-level controls of a 16-bit memory row port and the array. For each column access it produces the write data and a set of per-column, per-bit write enables. The controls are sampled when a row opens: the column-strobe state, the transfer select, the two byte write strobes and the function select. From them the block picks the row's mode and latches a per-bit write mask. That mask then governs every column access until the row closes.

In a normal row, a column access writes the data input into one column. In a block-write access, the block writes the internal color register into up to eight adjacent columns. In that case the data pins act as column selects and are applied separately to each byte. A flash row writes the masked color value across the whole row in a single cycle. A color row loads the color register from the data pins.

The enables for eight neighbouring columns leave the block as one flat vector, together with an aligned column base. Lane `c` bit `b` sits at position `c*16+b`.

The controller has five states:
- `ST_IDLE`: no row is open.
- `ST_ROW_RW`: a normal or block-write row.
- `ST_ROW_COLOR`: a color-load row.
- `ST_ROW_FLASH`: a one-cycle state that issues the flash write.
- `ST_ROW_HOLD`: a refresh or transfer row, or a flash row after its write.

State transitions:
- From `ST_IDLE`, `row_open` selects the next state.
  - `ST_ROW_HOLD` if `pre_col_strobe` or `pre_xfer` is set.
  - Otherwise `ST_ROW_COLOR` if `pre_func` is set and neither write strobe is set.
  - Otherwise `ST_ROW_FLASH` if `pre_func` is set with a write strobe.
  - Otherwise `ST_ROW_RW`.
- `ST_ROW_FLASH` always moves to `ST_ROW_HOLD`.
- Any row state returns to `ST_IDLE` on `row_close`.

Top module: `mbw_write_path`

## Requirements
- R1: After reset, `wr_valid`, `wr_flash`, `wr_bit_en`, `wr_data`, `wr_col_base` and `color_q` are all zero.
- R2: In a color row (`pre_func`=1, `pre_col_strobe`=`pre_xfer`=`pre_wr_lo`=`pre_wr_hi`=0 at `row_open`), a column access loads `color_q[7:0]` from `din[7:0]` when `col_wr_lo`=1. It loads `color_q[15:8]` from `din[15:8]` when `col_wr_hi`=1. It produces no array write.
- R3: At `row_open`, if either `pre_wr_lo` or `pre_wr_hi` is 1, the bit mask is set to `din`. Otherwise the mask is all ones. A mask bit of 0 blocks that bit position and 1 allows it.
- R4: The mask does not change until the row closes, whatever `din` carries during later column accesses of the same row.
- R5: A normal access (`col_func`=0) in a normal row writes `din` to lane `col_addr[2:0]`. It reports `wr_col_base` = `col_addr` with bits [2:0] cleared. Bit enables in that lane are the mask ANDed with the byte strobes, and all other lanes are zero.
- R6: A block access (`col_func`=1) writes `color_q` as data and ignores `col_addr[2:0]`. Lane `c` enables its lower byte when `din[c]`=1 and its upper byte when `din[8+c]`=1, in both cases ANDed with the mask and the byte strobes.
- R7: `col_wr_lo` gates only bits [7:0] of every lane and `col_wr_hi` gates only bits [15:8]. An access with neither strobe produces no write.
- R8: In a flash row (`pre_func`=1 with a write strobe at `row_open`), exactly one cycle after the open edge `wr_valid`=`wr_flash`=1 and `wr_data`=`color_q`. Every lane's enables equal the mask ANDed with the byte strobes sampled at `row_open`. Later column accesses in that row produce no write.
- R9: A row opened with `pre_col_strobe`=1 or `pre_xfer`=1 produces no write and leaves `color_q` unchanged.
- R10: A column access sampled on clock edge N gives its write outputs after edge N, held for exactly one cycle.
- R11: Column accesses while no row is open, or in the same cycle as `row_close`, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_open | input | 1 | Row strobe asserted this cycle |
| row_close | input | 1 | Row strobe released this cycle |
| pre_col_strobe | input | 1 | Column strobe already active at row open (refresh) |
| pre_xfer | input | 1 | Transfer select active at row open |
| pre_wr_lo | input | 1 | Lower write strobe active at row open |
| pre_wr_hi | input | 1 | Upper write strobe active at row open |
| pre_func | input | 1 | Function select at row open |
| col_go | input | 1 | Column access this cycle |
| col_func | input | 1 | Function select at column access (1 = block) |
| col_addr | input | 9 | Column address |
| col_wr_lo | input | 1 | Lower byte write strobe |
| col_wr_hi | input | 1 | Upper byte write strobe |
| din | input | 16 | Data pins |
| wr_valid | output | 1 | Array write this cycle |
| wr_flash | output | 1 | Write targets every column of the row |
| wr_col_base | output | 9 | Eight-aligned column base |
| wr_data | output | 16 | Write data |
| wr_bit_en | output | 128 | Per-lane, per-bit write enables |
| color_q | output | 16 | Color register contents |

## Verification
Some properties are checked by assertions on every cycle:
- the mask stays unchanged while a row is open;
- the color register changes only inside a color row;
- flash pulses last one cycle and follow the flash state;
- non-flash writes carry an eight-aligned base;
- idle and hold states produce no write.

Only the directed scenarios can confirm the actual values:
- the enable pattern of each lane for given column selects, masks and byte strobes;
- that block data comes from the previously loaded color;
- that a refresh or transfer row leaves the color untouched.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_RW,
        ST_ROW_COLOR,
        ST_ROW_FLASH,
        ST_ROW_HOLD
    } mbw_state_e;
endpackage

// File: rtl/mbw_mask_latch.sv
module mbw_mask_latch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              use_pins,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] mask_q
);
    // Captured once per row; all ones means every bit is writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (load) begin
            mask_q <= use_pins ? pins : '1;
        end
    end
endmodule

// File: rtl/mbw_color_reg.sv
module mbw_color_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] color_q
);
    localparam int BYTE_W = DATA_W / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            color_q <= '0;
        end else begin
            if (load_lo) color_q[BYTE_W-1:0]      <= pins[BYTE_W-1:0];
            if (load_hi) color_q[DATA_W-1:BYTE_W] <= pins[DATA_W-1:BYTE_W];
        end
    end
endmodule

// File: rtl/mbw_lane_decode.sv
module mbw_lane_decode #(
    parameter int DATA_W = 16,
    parameter int LANES  = 8
) (
    input  logic                    is_block,
    input  logic [$clog2(LANES)-1:0] lane_sel,
    input  logic [DATA_W-1:0]       pins,
    input  logic [DATA_W-1:0]       mask,
    input  logic                    byte_lo,
    input  logic                    byte_hi,
    output logic [LANES*DATA_W-1:0] bit_en
);
    localparam int BYTE_W = DATA_W / 2;
    localparam int LSEL_W = $clog2(LANES);

    for (genvar c = 0; c < LANES; c++) begin : g_lane
        logic pick_lo;
        logic pick_hi;
        // Block mode: pins act as per-byte column selects; otherwise one lane by address.
        assign pick_lo = is_block ? pins[c]        : (lane_sel == LSEL_W'(c));
        assign pick_hi = is_block ? pins[BYTE_W+c] : (lane_sel == LSEL_W'(c));
        assign bit_en[c*DATA_W +: BYTE_W] =
            mask[BYTE_W-1:0] & {BYTE_W{pick_lo & byte_lo}};
        assign bit_en[c*DATA_W+BYTE_W +: BYTE_W] =
            mask[DATA_W-1:BYTE_W] & {BYTE_W{pick_hi & byte_hi}};
    end
endmodule

// File: rtl/mbw_write_path.sv
module mbw_write_path
    import mbw_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = 8,
    parameter int COL_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    row_open,
    input  logic                    row_close,
    input  logic                    pre_col_strobe,
    input  logic                    pre_xfer,
    input  logic                    pre_wr_lo,
    input  logic                    pre_wr_hi,
    input  logic                    pre_func,
    input  logic                    col_go,
    input  logic                    col_func,
    input  logic [COL_W-1:0]        col_addr,
    input  logic                    col_wr_lo,
    input  logic                    col_wr_hi,
    input  logic [DATA_W-1:0]       din,
    output logic                    wr_valid,
    output logic                    wr_flash,
    output logic [COL_W-1:0]        wr_col_base,
    output logic [DATA_W-1:0]       wr_data,
    output logic [LANES*DATA_W-1:0] wr_bit_en,
    output logic [DATA_W-1:0]       color_q
);
    localparam int LSEL_W = $clog2(LANES);
    localparam int BYTE_W = DATA_W / 2;

    mbw_state_e state_q, state_d;
    logic [DATA_W-1:0]       mask_q;
    logic [LANES*DATA_W-1:0] dec_en;
    logic                    open_now;
    logic                    use_pins;
    logic                    col_live;
    logic                    flash_lo_q, flash_hi_q;

    assign open_now = row_open && (state_q == ST_IDLE);
    assign use_pins = pre_wr_lo | pre_wr_hi;
    assign col_live = col_go && !row_close;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (row_open) begin
                    if (pre_col_strobe || pre_xfer)  state_d = ST_ROW_HOLD;
                    else if (pre_func && !use_pins)  state_d = ST_ROW_COLOR;
                    else if (pre_func)               state_d = ST_ROW_FLASH;
                    else                             state_d = ST_ROW_RW;
                end
            end
            ST_ROW_RW, ST_ROW_COLOR, ST_ROW_HOLD: begin
                if (row_close) state_d = ST_IDLE;
            end
            ST_ROW_FLASH: begin
                state_d = row_close ? ST_IDLE : ST_ROW_HOLD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_lo_q <= 1'b0;
            flash_hi_q <= 1'b0;
        end else if (open_now) begin
            flash_lo_q <= pre_wr_lo;
            flash_hi_q <= pre_wr_hi;
        end
    end

    mbw_mask_latch #(.DATA_W(DATA_W)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (open_now),
        .use_pins (use_pins),
        .pins     (din),
        .mask_q   (mask_q)
    );

    mbw_color_reg #(.DATA_W(DATA_W)) u_color (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (state_q == ST_ROW_COLOR && col_live && col_wr_lo),
        .load_hi (state_q == ST_ROW_COLOR && col_live && col_wr_hi),
        .pins    (din),
        .color_q (color_q)
    );

    mbw_lane_decode #(.DATA_W(DATA_W), .LANES(LANES)) u_dec (
        .is_block (col_func),
        .lane_sel (col_addr[LSEL_W-1:0]),
        .pins     (din),
        .mask     (mask_q),
        .byte_lo  (col_wr_lo),
        .byte_hi  (col_wr_hi),
        .bit_en   (dec_en)
    );

    // Output process: one-cycle write pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid    <= 1'b0;
            wr_flash    <= 1'b0;
            wr_col_base <= '0;
            wr_data     <= '0;
            wr_bit_en   <= '0;
        end else begin
            wr_valid  <= 1'b0;
            wr_flash  <= 1'b0;
            wr_bit_en <= '0;
            unique case (state_q)
                ST_ROW_FLASH: begin
                    wr_valid    <= 1'b1;
                    wr_flash    <= 1'b1;
                    wr_col_base <= '0;
                    wr_data     <= color_q;
                    wr_bit_en   <= {LANES{mask_q &
                                   {{BYTE_W{flash_hi_q}}, {BYTE_W{flash_lo_q}}}}};
                end
                ST_ROW_RW: begin
                    if (col_live && (col_wr_lo || col_wr_hi)) begin
                        wr_valid    <= 1'b1;
                        wr_col_base <= {col_addr[COL_W-1:LSEL_W], {LSEL_W{1'b0}}};
                        wr_data     <= col_func ? color_q : din;
                        wr_bit_en   <= dec_en;
                    end
                end
                default: ;
            endcase
        end
    end

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !row_close) |=> $stable(mask_q));
    // R2
    color_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ROW_COLOR) |=> $stable(color_q));
    // R8
    flash_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flash |-> (wr_valid && $past(state_q) == ST_ROW_FLASH));
    // R10
    flash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flash |=> !wr_flash);
    // R6
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_flash) |-> (wr_col_base[LSEL_W-1:0] == '0));
    // R9
    quiet_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_ROW_HOLD || state_q == ST_ROW_COLOR)
        |=> !wr_valid);
endmodule

// File: tb/mbw_write_path_bench.sv
module mbw_write_path_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         row_open = 0, row_close = 0;
    logic         pre_col_strobe = 0, pre_xfer = 0, pre_wr_lo = 0, pre_wr_hi = 0, pre_func = 0;
    logic         col_go = 0, col_func = 0, col_wr_lo = 0, col_wr_hi = 0;
    logic [8:0]   col_addr = '0;
    logic [15:0]  din = '0;
    logic         wr_valid, wr_flash;
    logic [8:0]   wr_col_base;
    logic [15:0]  wr_data, color_q;
    logic [127:0] wr_bit_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mbw_write_path u_mbw_write_path (
        .clk(clk), .rst_n(rst_n), .row_open(row_open), .row_close(row_close),
        .pre_col_strobe(pre_col_strobe), .pre_xfer(pre_xfer), .pre_wr_lo(pre_wr_lo),
        .pre_wr_hi(pre_wr_hi), .pre_func(pre_func), .col_go(col_go), .col_func(col_func),
        .col_addr(col_addr), .col_wr_lo(col_wr_lo), .col_wr_hi(col_wr_hi), .din(din),
        .wr_valid(wr_valid), .wr_flash(wr_flash), .wr_col_base(wr_col_base),
        .wr_data(wr_data), .wr_bit_en(wr_bit_en), .color_q(color_q)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_en(bit blk, int lane, logic [15:0] d,
                                            logic [15:0] m, bit lo, bit hi);
        logic [127:0] r = '0;
        for (int c = 0; c < 8; c++) begin
            bit sl = blk ? d[c]   : (lane == c);
            bit sh = blk ? d[8+c] : (lane == c);
            for (int b = 0; b < 8; b++) begin
                r[c*16+b]   = m[b]   & sl & lo;
                r[c*16+8+b] = m[8+b] & sh & hi;
            end
        end
        return r;
    endfunction

    task automatic open_row(bit cs, bit xf, bit wl, bit wu, bit fn, logic [15:0] d);
        @(negedge clk);
        row_open = 1; pre_col_strobe = cs; pre_xfer = xf;
        pre_wr_lo = wl; pre_wr_hi = wu; pre_func = fn; din = d;
        @(negedge clk);
        row_open = 0; pre_col_strobe = 0; pre_xfer = 0;
        pre_wr_lo = 0; pre_wr_hi = 0; pre_func = 0;
    endtask

    task automatic column(bit fn, logic [8:0] a, bit wl, bit wu, logic [15:0] d);
        @(negedge clk);
        col_go = 1; col_func = fn; col_addr = a; col_wr_lo = wl; col_wr_hi = wu; din = d;
        @(negedge clk);
        col_go = 0; col_func = 0; col_wr_lo = 0; col_wr_hi = 0;
    endtask

    task automatic close_row();
        @(negedge clk); row_close = 1;
        @(negedge clk); row_close = 0;
    endtask

    task automatic load_color(logic [15:0] v);
        open_row(0, 0, 0, 0, 1, 16'h0000);
        column(0, 9'h000, 1, 1, v);
        close_row();
    endtask

    task automatic t_reset();
        chk("R1 wr_valid", 128'(wr_valid), 0);
        chk("R1 wr_flash", 128'(wr_flash), 0);
        chk("R1 bit_en", wr_bit_en, 0);
        chk("R1 data", 128'(wr_data), 0);
        chk("R1 base", 128'(wr_col_base), 0);
        chk("R1 color", 128'(color_q), 0);
    endtask

    task automatic t_color();
        open_row(0, 0, 0, 0, 1, 16'h0000);
        column(0, 9'h000, 1, 0, 16'hA5C3);
        chk("R2 color lo only", 128'(color_q), 128'h00C3);
        chk("R2 no array write", 128'(wr_valid), 0);
        column(0, 9'h000, 0, 1, 16'h7E11);
        chk("R2 color hi", 128'(color_q), 128'h7EC3);
        close_row();
    endtask

    task automatic t_normal();
        open_row(0, 0, 0, 0, 0, 16'h0000);
        column(0, 9'h013, 1, 1, 16'h1234);
        chk("R5 valid", 128'(wr_valid), 1);
        chk("R5 base", 128'(wr_col_base), 128'h010);
        chk("R5 data", 128'(wr_data), 128'h1234);
        chk("R3 unmasked en", wr_bit_en, exp_en(0, 3, 16'h1234, 16'hFFFF, 1, 1));
        @(negedge clk);
        chk("R10 one-cycle pulse", 128'(wr_valid), 0);
        close_row();
    endtask

    task automatic t_masked_page();
        open_row(0, 0, 1, 0, 0, 16'h0FF0);
        column(0, 9'h005, 1, 1, 16'hFFFF);
        chk("R3 mask applied", wr_bit_en, exp_en(0, 5, 16'hFFFF, 16'h0FF0, 1, 1));
        column(0, 9'h1FE, 1, 1, 16'h0000);
        chk("R4 mask retained", wr_bit_en, exp_en(0, 6, 16'h0, 16'h0FF0, 1, 1));
        chk("R4 base", 128'(wr_col_base), 128'h1F8);
        close_row();
    endtask

    task automatic t_bytes();
        open_row(0, 0, 0, 0, 0, 16'h0000);
        column(0, 9'h021, 1, 0, 16'hBBAA);
        chk("R7 lower only", wr_bit_en, exp_en(0, 1, 16'h0, 16'hFFFF, 1, 0));
        column(0, 9'h022, 0, 1, 16'hBBAA);
        chk("R7 upper only", wr_bit_en, exp_en(0, 2, 16'h0, 16'hFFFF, 0, 1));
        column(0, 9'h022, 0, 0, 16'hBBAA);
        chk("R7 no strobe no write", 128'(wr_valid), 0);
        close_row();
    endtask

    task automatic t_block();
        load_color(16'hBEEF);
        open_row(0, 0, 1, 1, 0, 16'hF0FF);
        column(1, 9'h0AF, 1, 1, 16'h3C81);
        chk("R6 base ignores low bits", 128'(wr_col_base), 128'h0A8);
        chk("R6 color data", 128'(wr_data), 128'hBEEF);
        chk("R6 lane enables", wr_bit_en, exp_en(1, 0, 16'h3C81, 16'hF0FF, 1, 1));
        column(1, 9'h0AF, 0, 1, 16'h3C81);
        chk("R7 block upper only", wr_bit_en, exp_en(1, 0, 16'h3C81, 16'hF0FF, 0, 1));
        close_row();
    endtask

    task automatic t_flash();
        load_color(16'h5A5A);
        open_row(0, 0, 1, 0, 1, 16'h33CC);
        @(negedge clk);
        chk("R8 flash flag", 128'({wr_valid, wr_flash}), 128'h3);
        chk("R8 flash data", 128'(wr_data), 128'h5A5A);
        chk("R8 flash enables", wr_bit_en, {8{16'h33CC & 16'h00FF}});
        column(0, 9'h004, 1, 1, 16'hFFFF);
        chk("R8 later column ignored", 128'(wr_valid), 0);
        close_row();
    endtask

    task automatic t_refresh_xfer();
        open_row(1, 0, 0, 0, 1, 16'h0000);
        column(0, 9'h003, 1, 1, 16'h1111);
        chk("R9 refresh no write", 128'(wr_valid), 0);
        chk("R9 refresh color kept", 128'(color_q), 128'h5A5A);
        close_row();
        open_row(0, 1, 0, 0, 1, 16'h0000);
        column(0, 9'h003, 1, 1, 16'h2222);
        chk("R9 transfer no write", 128'(wr_valid), 0);
        chk("R9 transfer color kept", 128'(color_q), 128'h5A5A);
        close_row();
    endtask

    task automatic t_idle_col();
        column(0, 9'h007, 1, 1, 16'h4444);
        chk("R11 idle column ignored", 128'(wr_valid), 0);
        open_row(0, 0, 0, 0, 0, 16'h0000);
        @(negedge clk);
        col_go = 1; col_addr = 9'h002; col_wr_lo = 1; col_wr_hi = 1; row_close = 1;
        @(negedge clk);
        col_go = 0; col_wr_lo = 0; col_wr_hi = 0; row_close = 0;
        chk("R11 column with close ignored", 128'(wr_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_color();
        t_normal();
        t_masked_page();
        t_bytes();
        t_block();
        t_flash();
        t_refresh_xfer();
        t_idle_col();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule